// File: doc/BRIEF.md
# Error Logging Unit with First-Error Capture

This block gathers error event pulses from five sources and keeps each group in its own sticky status register. There are two link groups, one management group, a non-fatal summary and a catastrophic/fatal summary. Software can clear a link or management group only by writing back the exact bit pattern it last read. Any other write is refused, and the response carries an error flag. The two summary registers can only be read.

Two capture registers record which group raised an error first and which raised one after that. They look only at the three clearable groups. Once loaded, they stay frozen until every clearable group has been cleared. A test-injection register can force bit 0 of any group whose injection is supported. The set of supported groups is fixed by a parameter.

Access goes through a plain register port. Each request is a valid strobe with an address, a write flag and write data. Exactly one cycle later the unit answers with a response valid, read data and an error flag.

Top module: `err_log_unit`

## Requirements
- R1: A source bit pulsed high for one cycle sets the matching status bit, and the bit holds for all later cycles until a successful clear or reset. This applies to all five groups: address 0 is link A, 1 is link B, 2 is management, 3 is non-fatal and 4 is catastrophic/fatal.
- R2: A write to address 0, 1 or 2 whose data equals the current register value, zero-extended to 32 bits, clears that register and responds with rsp_err = 0.
- R3: A write to address 0, 1 or 2 whose data differs from the current value responds with rsp_err = 1 and leaves the register unchanged.
- R4: The summary registers at addresses 3 and 4 are read-only. Writes to them, and writes to addresses 6 and 7, respond with rsp_err = 1 and change nothing.
- R5: The first-capture register reads at address 6. It loads when it is empty and an event hits a clearable group. Bit 31 is the valid flag, bits 18:16 hold the group address and bits 15:0 hold that group's event bits. When several groups fire in one cycle, the lowest address wins.
- R6: The next-capture register reads at address 7 and uses the same format. It loads on the first event in a later cycle while the first-capture register is full and next is empty. After that, both stay frozen.
- R7: The first-capture and next-capture registers both return to zero once all three clearable groups are zero. They remain loaded while any of those groups is nonzero.
- R8: When a new event and a matching clear hit the same group in the same cycle, the new event's bits remain set afterwards and the response has rsp_err = 0.
- R9: The injection register reads at address 5. Bit k of an accepted write is ORed into bit 0 of group k's source for as long as it stays set.
- R10: An injection write with any bit set outside the parameter INJ_MASK (default 5'b10101) responds with rsp_err = 1 and leaves the injection register unchanged.
- R11: Every request receives rsp_vld exactly one cycle later. Read data reflects register state before that cycle's updates. A read of an unmapped address (8 and above) returns 0 with rsp_err = 0, and a write to one returns rsp_err = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_link_a | input | GRP_W | Event pulses, link group A |
| src_link_b | input | GRP_W | Event pulses, link group B |
| src_mgmt | input | GRP_W | Event pulses, management group |
| src_nonfatal | input | GRP_W | Event pulses, non-fatal summary |
| src_catfatal | input | GRP_W | Event pulses, catastrophic/fatal summary |
| req_vld | input | 1 | Register request strobe |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | 32 | Write data |
| rsp_vld | output | 1 | Response strobe, one cycle after request |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Write rejected |

## Verification
A source pulse driven before a clock edge shows up in the status registers at that same edge. A read issued in the following cycle therefore returns the pulse one edge later. Every request is answered at the first edge after it is driven, so the bench drives on falling edges and samples rsp_vld, rsp_rdata and rsp_err at the next falling edge. Capture and clear effects come from the same edge as the request, so the bench checks them with a read in the following cycle. The clear-versus-event race is tested by driving both in the same half cycle.

// File: rtl/err_log_unit.sv
module err_log_unit #(
  parameter int GRP_W = 8,
  parameter int ADDR_W = 4,
  parameter logic [4:0] INJ_MASK = 5'b10101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GRP_W-1:0]  src_link_a,
  input  logic [GRP_W-1:0]  src_link_b,
  input  logic [GRP_W-1:0]  src_mgmt,
  input  logic [GRP_W-1:0]  src_nonfatal,
  input  logic [GRP_W-1:0]  src_catfatal,
  input  logic              req_vld,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_vld,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err
);
  localparam int NGRP = 5;
  localparam int NCLR = 3;
  localparam int A_INJ = 5;
  localparam int A_FST = 6;
  localparam int A_NXT = 7;

  logic [NGRP-1:0][GRP_W-1:0] st, st_nxt, ev;
  logic [NGRP-1:0] inj;
  logic [31:0] fst, nxt, cap, rdata_c;
  logic wr, any_ev, empty_nxt, err_c, inj_ok;

  assign wr = req_vld & req_wr;
  assign inj_ok = (req_wdata & ~{27'b0, INJ_MASK}) == 32'b0;

  always_comb begin
    ev[0] = src_link_a;
    ev[1] = src_link_b;
    ev[2] = src_mgmt;
    ev[3] = src_nonfatal;
    ev[4] = src_catfatal;
    for (int k = 0; k < NGRP; k++) ev[k][0] = ev[k][0] | inj[k];
  end

  always_comb begin
    for (int k = 0; k < NGRP; k++) begin
      st_nxt[k] = st[k] | ev[k];
      if (k < NCLR && wr && int'(req_addr) == k && req_wdata == 32'(st[k]))
        st_nxt[k] = ev[k];
    end
  end

  always_comb begin
    any_ev = 1'b0;
    cap = '0;
    for (int k = NCLR - 1; k >= 0; k--) begin
      if (ev[k] != '0) begin
        any_ev = 1'b1;
        cap = {1'b1, 12'b0, 3'(k), 16'(ev[k])};
      end
    end
  end

  assign empty_nxt = (st_nxt[0] == '0) && (st_nxt[1] == '0) && (st_nxt[2] == '0);

  always_comb begin
    err_c = 1'b0;
    if (wr) begin
      if (int'(req_addr) < NCLR) err_c = req_wdata != 32'(st[req_addr]);
      else if (int'(req_addr) == A_INJ) err_c = !inj_ok;
      else err_c = 1'b1;
    end
  end

  always_comb begin
    rdata_c = '0;
    if (int'(req_addr) < NGRP) rdata_c = 32'(st[req_addr]);
    else if (int'(req_addr) == A_INJ) rdata_c = 32'(inj);
    else if (int'(req_addr) == A_FST) rdata_c = fst;
    else if (int'(req_addr) == A_NXT) rdata_c = nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= '0;
      inj <= '0;
      fst <= '0;
      nxt <= '0;
      rsp_vld <= 1'b0;
      rsp_rdata <= '0;
      rsp_err <= 1'b0;
    end else begin
      st <= st_nxt;
      if (wr && int'(req_addr) == A_INJ && inj_ok) inj <= req_wdata[NGRP-1:0];
      if (empty_nxt) begin
        fst <= '0;
        nxt <= '0;
      end else if (!fst[31] && any_ev) fst <= cap;
      else if (fst[31] && !nxt[31] && any_ev) nxt <= cap;
      rsp_vld <= req_vld;
      rsp_err <= req_vld & err_c;
      rsp_rdata <= (req_vld && !req_wr) ? rdata_c : 32'b0;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NCLR; g++) begin : g_chk
      assert_sticky_until_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(st[g]) & ~st[g]) != '0) |-> $past(req_vld && req_wr && int'(req_addr) == g));
    end
  endgenerate

  assert_summary_never_falls_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(st[3]) & ~st[3]) == '0) && (($past(st[4]) & ~st[4]) == '0));
  assert_first_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fst[31] && $past(fst[31])) |-> $stable(fst));
  assert_next_after_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nxt[31] |-> fst[31]);
  assert_inj_in_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (inj & ~INJ_MASK) == '0);
  assert_read_no_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && !$past(req_wr)) |-> !rsp_err);
  assert_err_has_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_vld);
endmodule

// File: tb/err_log_unit_tb.sv
module err_log_unit_tb_top;
  logic clk = 0, rst_n = 0;
  logic [7:0] s0 = 0, s1 = 0, s2 = 0, s3 = 0, s4 = 0;
  logic req_vld = 0, req_wr = 0;
  logic [3:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic rsp_vld, rsp_err;
  logic [31:0] rsp_rdata;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  err_log_unit dut_i (.clk(clk), .rst_n(rst_n), .src_link_a(s0), .src_link_b(s1),
    .src_mgmt(s2), .src_nonfatal(s3), .src_catfatal(s4), .req_vld(req_vld),
    .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_vld(rsp_vld), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err));

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(int a, string tag, logic [31:0] exp);
    req_vld = 1; req_wr = 0; req_addr = 4'(a);
    @(negedge clk);
    req_vld = 0;
    chk({tag, " rsp_vld"}, 32'(rsp_vld), 1);
    chk({tag, " rsp_err"}, 32'(rsp_err), 0);
    chk(tag, rsp_rdata, exp);
  endtask

  task automatic wr(int a, logic [31:0] d, string tag, bit exp_err);
    req_vld = 1; req_wr = 1; req_addr = 4'(a); req_wdata = d;
    @(negedge clk);
    req_vld = 0; req_wr = 0;
    chk({tag, " rsp_vld"}, 32'(rsp_vld), 1);
    chk({tag, " rsp_err"}, 32'(rsp_err), 32'(exp_err));
  endtask

  task automatic pulse(logic [7:0] a, logic [7:0] b, logic [7:0] m, logic [7:0] n, logic [7:0] c);
    s0 = a; s1 = b; s2 = m; s3 = n; s4 = c;
    @(negedge clk);
    s0 = 0; s1 = 0; s2 = 0; s3 = 0; s4 = 0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 8; a++) rd(a, "R11 reset read", 0);
    rd(9, "R11 unmapped read", 0);
  endtask

  task automatic t_first_next;
    pulse(0, 8'h22, 0, 0, 0);
    rd(6, "R5 first capture", 32'h8001_0022);
    rd(7, "R6 next empty", 0);
    pulse(0, 0, 8'h03, 0, 0);
    rd(7, "R6 next capture", 32'h8002_0003);
    pulse(8'h01, 0, 0, 0, 0);
    rd(6, "R6 first frozen", 32'h8001_0022);
    rd(7, "R6 next frozen", 32'h8002_0003);
    rd(1, "R1 link B sticky", 8'h22);
    rd(0, "R1 link A sticky", 8'h01);
    wr(0, 32'h02, "R3 mismatch clear", 1);
    rd(0, "R3 unchanged", 8'h01);
    wr(1, 32'h122, "R3 upper bits mismatch", 1);
    rd(1, "R3 unchanged B", 8'h22);
    wr(0, 32'h01, "R2 clear A", 0);
    rd(0, "R2 cleared A", 0);
    wr(1, 32'h22, "R2 clear B", 0);
    rd(6, "R7 first kept", 32'h8001_0022);
    wr(2, 32'h03, "R2 clear mgmt", 0);
    rd(6, "R7 first emptied", 0);
    rd(7, "R7 next emptied", 0);
  endtask

  task automatic t_simul;
    pulse(0, 8'h04, 8'h08, 0, 0);
    rd(6, "R5 lowest group wins", 32'h8001_0004);
    rd(7, "R5 next not same cycle", 0);
    wr(1, 32'h04, "R2 clear B", 0);
    wr(2, 32'h08, "R2 clear mgmt", 0);
    rd(6, "R7 empty", 0);
  endtask

  task automatic t_race;
    pulse(8'h01, 0, 0, 0, 0);
    s0 = 8'h40;
    wr(0, 32'h01, "R8 race clear", 0);
    s0 = 0;
    rd(0, "R8 event wins", 8'h40);
    wr(0, 32'h40, "R2 clear A", 0);
    rd(0, "R2 A zero", 0);
  endtask

  task automatic t_summary;
    pulse(0, 0, 0, 8'h09, 8'h02);
    rd(3, "R1 nonfatal sticky", 8'h09);
    rd(4, "R1 catfatal sticky", 8'h02);
    rd(6, "R5 summaries not captured", 0);
    wr(3, 32'h09, "R4 write nonfatal", 1);
    rd(3, "R4 nonfatal unchanged", 8'h09);
    wr(4, 32'h02, "R4 write catfatal", 1);
    rd(4, "R4 catfatal unchanged", 8'h02);
    wr(6, 32'h0, "R4 write first", 1);
  endtask

  task automatic t_inject;
    wr(5, 32'h02, "R10 unsupported inject", 1);
    rd(5, "R10 inject unchanged", 0);
    rd(1, "R10 no effect on B", 0);
    wr(5, 32'h04, "R9 inject mgmt", 0);
    rd(5, "R9 inject readback", 32'h04);
    rd(2, "R9 mgmt forced", 8'h01);
    rd(6, "R9 first from inject", 32'h8002_0001);
    wr(5, 32'h00, "R9 inject off", 0);
    wr(2, 32'h01, "R2 clear mgmt", 0);
    rd(2, "R2 mgmt zero", 0);
    wr(5, 32'h100, "R10 out of range", 1);
  endtask

  task automatic t_unmapped;
    rd(12, "R11 unmapped read", 0);
    wr(12, 32'h5, "R11 unmapped write", 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 rsp idle", 32'(rsp_vld), 0);
    t_reset;
    t_first_next;
    t_simul;
    t_race;
    t_summary;
    t_inject;
    t_unmapped;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule